// File: doc/BRIEF.md
# Boot-Time Register Burst Loader

This sequencer runs once per start request, after the configuration straps have settled. It first pushes six whole-register default values onto a 32-bit register write bus. These go to the advertisement and control words of the physical and virtual PHY, and to the LED and manual flow-control configuration words. Each control word goes out with its restart-auto-negotiation bit forced on, so that the fresh advertisement takes effect. Each value replaces the whole register, so nothing written to it earlier survives.

It then reads a byte-addressed serial EEPROM image through a simple request/acknowledge byte port. The image may hold an optional block of register bursts. A flag byte at offset 12 enables that block. The byte after it gives the number of bursts. Each burst is a big-endian 16-bit start address, a one-byte word count, and four data bytes per word. The loader turns every group of four bytes into one 32-bit write to consecutive word addresses. When the sequence is over, the busy output drops, and an optional one-cycle interrupt pulse marks that moment.

Top module: `eeLoader`

## Requirements
- R1: A one-cycle `start` while idle raises `busy` on the next cycle. A `start` while `busy` is high is ignored: it adds no writes and no EEPROM reads.
- R2: The first writes of a load are exactly six, in this order: PHY advertisement, PHY control, virtual PHY advertisement, virtual PHY control, LED configuration, flow-control configuration. Each carries the whole value of its default input.
- R3: Both control-word writes carry their default input with bit 9 (restart auto-negotiation) forced to 1 and every other bit unchanged.
- R4: The EEPROM is first read at byte 12. Only the value 8'hA5 there lets burst parsing go on. Any other value ends the load after that single read.
- R5: Byte 13 gives the burst total. A total of zero ends the load after two EEPROM reads and no burst writes.
- R6: Each burst is a high address byte, then a low address byte, then a count byte. The writes go to that address with bits 1:0 cleared, then step by 4, wrapping at 16 bits.
- R7: The four data bytes of a word arrive least significant first and form data bits 7:0, 15:8, 23:16 and 31:24. A word is written only after its fourth byte arrives.
- R8: A count of zero gives no writes. The next EEPROM byte read is then the next burst's high address byte.
- R9: `busy` stays high from the cycle after `start` until after the last write. `regWe` and `romReq` are asserted only while `busy` is high. A pending `romReq` keeps `romAddr` steady until `romAck`.
- R10: `irq` is a one-cycle pulse on the first cycle that `busy` is low after a load, but only when `intEn` is high. It never pulses otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (ignored while busy) |
| intEn | input | 1 | Enables the completion interrupt pulse |
| phyAdvDef | input | 32 | Strap default for PHY advertisement word |
| phyCtrlDef | input | 32 | Strap default for PHY control word |
| vphyAdvDef | input | 32 | Strap default for virtual PHY advertisement word |
| vphyCtrlDef | input | 32 | Strap default for virtual PHY control word |
| ledDef | input | 32 | Strap default for LED configuration word |
| flowDef | input | 32 | Strap default for manual flow-control word |
| romReq | output | 1 | EEPROM byte read request, held until acknowledged |
| romAddr | output | 9 | EEPROM byte address |
| romAck | input | 1 | EEPROM byte valid this cycle |
| romData | input | 8 | EEPROM byte |
| regWe | output | 1 | Register write strobe |
| regAddr | output | 16 | Register byte address (word aligned) |
| regWdata | output | 32 | Register write data |
| busy | output | 1 | Load in progress |
| irq | output | 1 | Completion pulse |

## Verification
The assertions watch the handshake and framing rules on every cycle. They check that busy rises only in answer to start, that writes and EEPROM requests stay inside the busy window, that a pending request holds its address, that every write address is word aligned, and that the interrupt coincides with busy falling and follows the enable. The values and the order of writes can only be seen in the bench's scenarios. So can the flag and zero-total early exits, the effect of a zero count, byte-lane order, address stepping and wrap, and a start ignored mid-run. The bench builds a queue of expected writes from each EEPROM image and compares it with what the block puts out.

// File: rtl/eeLoaderPkg.sv
package eeLoaderPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RESYNC,
    ST_FLAG,
    ST_TOTAL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_COUNT,
    ST_DATA,
    ST_FINISH
  } ldState_e;

  // control -> datapath
  typedef struct packed {
    logic init;
    logic resyncWr;
    logic byteTake;
    logic capTotal;
    logic capHi;
    logic capLo;
    logic capCount;
    logic capData;
    logic burstDone;
  } ldStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic flagOk;
    logic byteZero;
    logic resyncLast;
    logic totalLast;
    logic countLast;
    logic laneLast;
  } ldStatus_t;

endpackage

// File: rtl/eeLoaderCtrl.sv
module eeLoaderCtrl
  import eeLoaderPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      intEn,
  input  logic      romAck,
  input  ldStatus_t status,
  output ldStrobe_t strobe,
  output logic      romReq,
  output logic      busy,
  output logic      irq
);

  ldState_e state, stateNext;
  logic     irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      irqQ  <= 1'b0;
    end else begin
      state <= stateNext;
      irqQ  <= (state == ST_FINISH) && intEn;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.init = 1'b1;
          stateNext   = ST_RESYNC;
        end
      end
      ST_RESYNC: begin
        strobe.resyncWr = 1'b1;
        if (status.resyncLast) stateNext = ST_FLAG;
      end
      ST_FLAG: begin
        if (romAck) begin
          strobe.byteTake = 1'b1;
          stateNext = status.flagOk ? ST_TOTAL : ST_FINISH;
        end
      end
      ST_TOTAL: begin
        if (romAck) begin
          strobe.byteTake = 1'b1;
          strobe.capTotal = 1'b1;
          stateNext = status.byteZero ? ST_FINISH : ST_ADDR_HI;
        end
      end
      ST_ADDR_HI: begin
        if (romAck) begin
          strobe.byteTake = 1'b1;
          strobe.capHi    = 1'b1;
          stateNext       = ST_ADDR_LO;
        end
      end
      ST_ADDR_LO: begin
        if (romAck) begin
          strobe.byteTake = 1'b1;
          strobe.capLo    = 1'b1;
          stateNext       = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (romAck) begin
          strobe.byteTake = 1'b1;
          strobe.capCount = 1'b1;
          if (status.byteZero) begin
            strobe.burstDone = 1'b1;
            stateNext = status.totalLast ? ST_FINISH : ST_ADDR_HI;
          end else begin
            stateNext = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (romAck) begin
          strobe.byteTake = 1'b1;
          strobe.capData  = 1'b1;
          if (status.laneLast && status.countLast) begin
            strobe.burstDone = 1'b1;
            stateNext = status.totalLast ? ST_FINISH : ST_ADDR_HI;
          end
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    romReq = (state == ST_FLAG) || (state == ST_TOTAL) || (state == ST_ADDR_HI) ||
             (state == ST_ADDR_LO) || (state == ST_COUNT) || (state == ST_DATA);
  end

  assign busy = (state != ST_IDLE);
  assign irq  = irqQ;

endmodule

// File: rtl/eeLoaderDatapath.sv
module eeLoaderDatapath
  import eeLoaderPkg::*;
#(
  parameter int ROM_AW         = 9,
  parameter int DATA_W         = 32,
  parameter int FLAG_BYTE      = 12,
  parameter logic [7:0] FLAG_VALUE = 8'hA5,
  parameter int RESTART_BIT    = 9,
  parameter logic [15:0] PHY_ADV_ADDR   = 16'h0110,
  parameter logic [15:0] PHY_CTRL_ADDR  = 16'h0100,
  parameter logic [15:0] VPHY_ADV_ADDR  = 16'h0210,
  parameter logic [15:0] VPHY_CTRL_ADDR = 16'h0200,
  parameter logic [15:0] LED_ADDR       = 16'h01BC,
  parameter logic [15:0] FLOW_ADDR      = 16'h01AC
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldStrobe_t         strobe,
  input  logic [7:0]        romData,
  input  logic [DATA_W-1:0] phyAdvDef,
  input  logic [DATA_W-1:0] phyCtrlDef,
  input  logic [DATA_W-1:0] vphyAdvDef,
  input  logic [DATA_W-1:0] vphyCtrlDef,
  input  logic [DATA_W-1:0] ledDef,
  input  logic [DATA_W-1:0] flowDef,
  output ldStatus_t         status,
  output logic [ROM_AW-1:0] romAddr,
  output logic              regWe,
  output logic [15:0]       regAddr,
  output logic [DATA_W-1:0] regWdata
);

  localparam int ADDR_W   = 16;
  localparam int RESYNC_N = 6;
  localparam int IDX_W    = $clog2(RESYNC_N);
  localparam int LANES    = DATA_W / 8;
  localparam int LANE_W   = $clog2(LANES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK   = ADDR_W'(LANES - 1);
  localparam logic [DATA_W-1:0] RESTART_MASK = DATA_W'(1) << RESTART_BIT;

  logic [ROM_AW-1:0] bytePtr;
  logic [IDX_W-1:0]  resyncIdx;
  logic [7:0]        totalLeft;
  logic [7:0]        wordsLeft;
  logic [7:0]        addrHi;
  logic [ADDR_W-1:0] wordAddr;
  logic [LANE_W-1:0] laneIdx;
  logic [7:0]        laneReg [LANES-1];
  logic [DATA_W-1:0] asmWord;
  logic [ADDR_W-1:0] rsAddr;
  logic [DATA_W-1:0] rsData;

  // whole-register resync values; control words re-trigger negotiation
  always_comb begin
    rsAddr = '0;
    rsData = '0;
    case (resyncIdx)
      IDX_W'(0): begin rsAddr = PHY_ADV_ADDR;   rsData = phyAdvDef; end
      IDX_W'(1): begin rsAddr = PHY_CTRL_ADDR;  rsData = phyCtrlDef | RESTART_MASK; end
      IDX_W'(2): begin rsAddr = VPHY_ADV_ADDR;  rsData = vphyAdvDef; end
      IDX_W'(3): begin rsAddr = VPHY_CTRL_ADDR; rsData = vphyCtrlDef | RESTART_MASK; end
      IDX_W'(4): begin rsAddr = LED_ADDR;       rsData = ledDef; end
      IDX_W'(5): begin rsAddr = FLOW_ADDR;      rsData = flowDef; end
      default:   begin rsAddr = '0;             rsData = '0; end
    endcase
  end

  // byte lanes: lower lanes are held, the top lane is the byte arriving now
  for (genvar g = 0; g < LANES - 1; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) laneReg[g] <= '0;
      else if (strobe.capData && laneIdx == LANE_W'(g)) laneReg[g] <= romData;
    end
    assign asmWord[8*g +: 8] = laneReg[g];
  end
  assign asmWord[DATA_W-1 -: 8] = romData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bytePtr   <= '0;
      resyncIdx <= '0;
      totalLeft <= '0;
      wordsLeft <= '0;
      addrHi    <= '0;
      wordAddr  <= '0;
      laneIdx   <= '0;
      regWe     <= 1'b0;
      regAddr   <= '0;
      regWdata  <= '0;
    end else begin
      regWe <= 1'b0;
      if (strobe.init) begin
        bytePtr   <= ROM_AW'(FLAG_BYTE);
        resyncIdx <= '0;
        laneIdx   <= '0;
      end
      if (strobe.byteTake) bytePtr <= bytePtr + 1'b1;
      if (strobe.resyncWr) begin
        resyncIdx <= resyncIdx + 1'b1;
        regWe     <= 1'b1;
        regAddr   <= rsAddr;
        regWdata  <= rsData;
      end
      if (strobe.capTotal) totalLeft <= romData;
      if (strobe.capHi)    addrHi    <= romData;
      if (strobe.capLo)    wordAddr  <= {addrHi, romData} & ~ALIGN_MASK;
      if (strobe.capCount) begin
        wordsLeft <= romData;
        laneIdx   <= '0;
      end
      if (strobe.capData) begin
        if (laneIdx == LANE_W'(LANES - 1)) begin
          regWe     <= 1'b1;
          regAddr   <= wordAddr;
          regWdata  <= asmWord;
          wordAddr  <= wordAddr + ADDR_W'(LANES);
          wordsLeft <= wordsLeft - 8'd1;
          laneIdx   <= '0;
        end else begin
          laneIdx <= laneIdx + 1'b1;
        end
      end
      if (strobe.burstDone) totalLeft <= totalLeft - 8'd1;
    end
  end

  assign status.flagOk     = (romData == FLAG_VALUE);
  assign status.byteZero   = (romData == 8'd0);
  assign status.resyncLast = (resyncIdx == IDX_W'(RESYNC_N - 1));
  assign status.totalLast  = (totalLeft == 8'd1);
  assign status.countLast  = (wordsLeft == 8'd1);
  assign status.laneLast   = (laneIdx == LANE_W'(LANES - 1));
  assign romAddr           = bytePtr;

endmodule

// File: rtl/eeLoader.sv
module eeLoader
  import eeLoaderPkg::*;
#(
  parameter int ROM_AW      = 9,
  parameter int FLAG_BYTE   = 12,
  parameter int RESTART_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              intEn,
  input  logic [31:0]       phyAdvDef,
  input  logic [31:0]       phyCtrlDef,
  input  logic [31:0]       vphyAdvDef,
  input  logic [31:0]       vphyCtrlDef,
  input  logic [31:0]       ledDef,
  input  logic [31:0]       flowDef,
  output logic              romReq,
  output logic [ROM_AW-1:0] romAddr,
  input  logic              romAck,
  input  logic [7:0]        romData,
  output logic              regWe,
  output logic [15:0]       regAddr,
  output logic [31:0]       regWdata,
  output logic              busy,
  output logic              irq
);

  ldStrobe_t strobe;
  ldStatus_t status;

  eeLoaderCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .intEn  (intEn),
    .romAck (romAck),
    .status (status),
    .strobe (strobe),
    .romReq (romReq),
    .busy   (busy),
    .irq    (irq)
  );

  eeLoaderDatapath #(
    .ROM_AW      (ROM_AW),
    .DATA_W      (32),
    .FLAG_BYTE   (FLAG_BYTE),
    .RESTART_BIT (RESTART_BIT)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .romData     (romData),
    .phyAdvDef   (phyAdvDef),
    .phyCtrlDef  (phyCtrlDef),
    .vphyAdvDef  (vphyAdvDef),
    .vphyCtrlDef (vphyCtrlDef),
    .ledDef      (ledDef),
    .flowDef     (flowDef),
    .status      (status),
    .romAddr     (romAddr),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .regWdata    (regWdata)
  );

endmodule

// File: rtl/eeLoaderChecker.sv
module eeLoaderChecker #(
  parameter int ROM_AW = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              intEn,
  input logic              busy,
  input logic              irq,
  input logic              romReq,
  input logic              romAck,
  input logic [ROM_AW-1:0] romAddr,
  input logic              regWe,
  input logic [15:0]       regAddr
);

  assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_write_in_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> busy);

  assert_rom_in_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    romReq |-> busy);

  assert_rom_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (romReq && !romAck) |=> (romReq && $stable(romAddr)));

  assert_word_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (regAddr[1:0] == 2'b00));

  assert_irq_on_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $fell(busy));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (irq == $past(intEn)));

endmodule

bind eeLoader eeLoaderChecker #(.ROM_AW(ROM_AW)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .intEn   (intEn),
  .busy    (busy),
  .irq     (irq),
  .romReq  (romReq),
  .romAck  (romAck),
  .romAddr (romAddr),
  .regWe   (regWe),
  .regAddr (regAddr)
);

// File: tb/tb_eeLoader.sv
module tb_eeLoader;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic        intEn;
  logic [31:0] phyAdvDef, phyCtrlDef, vphyAdvDef, vphyCtrlDef, ledDef, flowDef;
  logic        romReq;
  logic [8:0]  romAddr;
  logic        romAck;
  logic [7:0]  romData;
  logic        regWe;
  logic [15:0] regAddr;
  logic [31:0] regWdata;
  logic        busy;
  logic        irq;

  always #2 clk = ~clk;  // 250 MHz

  eeLoader dut (
    .clk(clk), .rstN(rstN), .start(start), .intEn(intEn),
    .phyAdvDef(phyAdvDef), .phyCtrlDef(phyCtrlDef), .vphyAdvDef(vphyAdvDef),
    .vphyCtrlDef(vphyCtrlDef), .ledDef(ledDef), .flowDef(flowDef),
    .romReq(romReq), .romAddr(romAddr), .romAck(romAck), .romData(romData),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busy(busy), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  mem [0:511];
  logic [47:0] expQ[$];
  string       tagQ[$];
  int          lat = 0;
  int          waitCnt = 0;
  int          readCount = 0;
  int          irqCount = 0;
  int          expReads = 0;
  bit          monOn = 0;
  logic        prevBusy = 1'b0;
  int          wp = 0;

  task automatic check(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // EEPROM responder: acknowledges after lat wait cycles
  always @(negedge clk) begin
    if (romReq) begin
      if (waitCnt >= lat) begin
        romAck  <= 1'b1;
        romData <= mem[romAddr];
        waitCnt <= 0;
        readCount <= readCount + 1;
      end else begin
        romAck  <= 1'b0;
        waitCnt <= waitCnt + 1;
      end
    end else begin
      romAck  <= 1'b0;
      waitCnt <= 0;
    end
  end

  // per-clock reference comparison
  always @(negedge clk) begin
    if (monOn) begin
      if (regWe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected write", {regAddr, regWdata}, 48'h0);
        end else begin
          logic [47:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({regAddr, regWdata} == e, t, {regAddr, regWdata}, e);
        end
        check(busy == 1'b1, "R9 write outside busy", {47'd0, busy}, 48'd1);
      end
      if (irq || (prevBusy && !busy && intEn))
        check(irq == (prevBusy && !busy && intEn), "R10 irq timing",
              {47'd0, irq}, {47'd0, prevBusy && !busy && intEn});
      if (irq) irqCount++;
      prevBusy = busy;
    end
  end

  task automatic put(input logic [7:0] b);
    mem[wp] = b;
    wp++;
  endtask

  task automatic pushExp(input logic [15:0] a, input logic [31:0] d, input string t);
    expQ.push_back({a, d});
    tagQ.push_back(t);
  endtask

  // builds expected write stream and read count from the image
  task automatic buildExpect();
    int p;
    int total;
    logic [15:0] a;
    int cnt;
    pushExp(16'h0110, phyAdvDef, "R2 phy adv");
    pushExp(16'h0100, phyCtrlDef | 32'h200, "R3 phy ctrl");
    pushExp(16'h0210, vphyAdvDef, "R2 vphy adv");
    pushExp(16'h0200, vphyCtrlDef | 32'h200, "R3 vphy ctrl");
    pushExp(16'h01BC, ledDef, "R2 led");
    pushExp(16'h01AC, flowDef, "R2 flow");
    expReads = 1;
    if (mem[12] == 8'hA5) begin
      expReads++;
      total = int'(mem[13]);
      p = 14;
      for (int b = 0; b < total; b++) begin
        a   = {mem[p], mem[p+1]} & 16'hFFFC;
        cnt = int'(mem[p+2]);
        p += 3;
        expReads += 3;
        for (int w = 0; w < cnt; w++) begin
          pushExp(a, {mem[p+3], mem[p+2], mem[p+1], mem[p]}, "R6/R7 burst word");
          a = a + 16'd4;
          p += 4;
          expReads += 4;
        end
      end
    end
  endtask

  task automatic clearImage();
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
    wp = 12;
  endtask

  task automatic runLoad(input int l, input bit ie, input int restartAt, input string tag);
    int cyc;
    lat = l;
    intEn = ie;
    readCount = 0;
    irqCount = 0;
    expQ.delete();
    tagQ.delete();
    buildExpect();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", {47'd0, busy}, 48'd1);
    cyc = 0;
    while (busy && cyc < 5000) begin
      @(negedge clk);
      start = (cyc == restartAt);
      cyc++;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, {tag, " R2 missing writes"}, 48'(expQ.size()), 48'd0);
    check(readCount == expReads, {tag, " R4/R5/R8 read count"}, 48'(readCount),
          48'(expReads));
    check(irqCount == (ie ? 1 : 0), {tag, " R10 irq count"}, 48'(irqCount),
          48'(ie ? 1 : 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; start = 1'b0; intEn = 1'b0;
    romAck = 1'b0; romData = 8'h00;
    phyAdvDef = 32'h0000_01E1; phyCtrlDef = 32'h0000_3100;
    vphyAdvDef = 32'h0000_05E1; vphyCtrlDef = 32'h0000_1000;
    ledDef = 32'h0000_0007; flowDef = 32'h0000_0F0F;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, irq, regWe, romReq} == 4'b0000, "R9 reset state",
          {44'd0, busy, irq, regWe, romReq}, 48'd0);
    monOn = 1;

    // invalid flag, interrupt enabled
    clearImage(); mem[12] = 8'h00;
    runLoad(0, 1'b1, -1, "R4 bad flag");

    // valid flag, zero total, interrupt disabled
    clearImage(); put(8'hA5); put(8'h00);
    runLoad(1, 1'b0, -1, "R5 zero total");

    // three bursts incl. zero count and unaligned address; start ignored mid-run
    clearImage(); put(8'hA5); put(8'd3);
    put(8'h00); put(8'h40); put(8'd2);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    put(8'hA1); put(8'hB2); put(8'hC3); put(8'hD4);
    put(8'h01); put(8'h05); put(8'd0);
    put(8'h10); put(8'h03); put(8'd1);
    put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF);
    runLoad(1, 1'b1, 15, "R1 R8 multi-burst");

    // near-miss flag with longer latency and new straps
    phyCtrlDef = 32'hFFFF_FDFF; vphyCtrlDef = 32'h0000_0200;
    ledDef = 32'h1234_5678; flowDef = 32'h8765_4321;
    clearImage(); put(8'hA4);
    runLoad(2, 1'b1, -1, "R4 near miss");

    // address wrap across 16 bits, zero latency
    clearImage(); put(8'hA5); put(8'd1);
    put(8'hFF); put(8'hF8); put(8'd3);
    for (int i = 0; i < 12; i++) put(8'(8'h60 + i));
    runLoad(0, 1'b1, -1, "R6 wrap");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule